// File: doc/BRIEF.md
# Interrupt Arbiter with Sequential and Nested Modes

The arbiter collects interrupt requests from four classes of cause (program fault, I/O completion or error, timer, hardware failure) and hands them to a processor one at a time. Every request pulse is held as pending until the processor takes it. The arbiter raises `cpu_req` with a class code on `cpu_class`. The processor takes that class with a one-cycle `cpu_ack` and, when its handler finishes, reports this with a one-cycle `cpu_eoi`.

A static input selects the policy. In sequential mode, delivery stops while any handler runs. Pending classes wait and are then served strictly in the order they arrived, whatever their rank. In nested mode, each class has a fixed rank equal to its code. A pending class that outranks the running handler is offered at once. On end-of-handler, control falls back to the preempted handler. A lower pending class is offered only when no handler of equal or higher rank remains in service.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cpu_req` is low and no class is pending or in service.
- R2: A cycle with `irq_in[c]` high makes class c pending. The class codes are 0 program fault, 1 I/O, 2 timer and 3 hardware failure. A pending class that is eligible under the mode is offered on the next cycle with `cpu_req` high and `cpu_class` = c.
- R3: A cycle with `cpu_ack` high while `cpu_req` is high puts the offered class in service and clears its pending bit. With nothing else eligible, `cpu_req` is low on the following cycle.
- R4: In sequential mode (`mode_nested` = 0), `cpu_req` stays low while any handler is in service. Requests arriving in that time are kept and offered after `cpu_eoi`.
- R5: In sequential mode, pending classes are offered in arrival order, regardless of rank. Classes arriving in the same cycle are queued with the higher code first.
- R6: A request for a class that is already pending is not queued a second time. The class is served once.
- R7: In nested mode (`mode_nested` = 1), a pending class whose code is greater than the highest class in service is offered immediately, while the lower handler is still in service.
- R8: In nested mode, a pending class whose code is equal to or lower than the highest class in service is not offered until the handlers above it have ended.
- R9: `cpu_eoi` ends the highest class in service. In nested mode, the preempted handler becomes active again, and a pending class ranked below it is not offered until it also ends.
- R10: A request for a class that arrives while that same class is in service is latched as pending again and is offered after its handler ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_nested | input | 1 | Static policy select: 0 sequential, 1 nested by rank |
| irq_in | input | N_SRC | Request per class, bit index = class code |
| cpu_req | output | 1 | A class is offered to the processor |
| cpu_class | output | ID_W | Code of the offered class |
| cpu_ack | input | 1 | Processor takes the offered class (one cycle) |
| cpu_eoi | input | 1 | Processor ends its current highest handler (one cycle) |

## Verification
In sequential mode, all 24 arrival orders of the four classes are driven, one class per cycle, and the service order is compared with the arrival order. Any ordering by rank, or by the last arrival, would fail this sweep. Simultaneous arrivals, duplicate pulses and re-requests during a class's own service separate the same-cycle tie rule, the no-duplicate rule and the re-latch rule. In nested mode, every ordered pair of active class and newcomer is tried. This separates preemption by a higher class from waiting by an equal or lower one. An extra low-rank request placed under a preempted handler shows whether end-of-handler returns to the preempted level before anything lower is offered.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   localparam int unsigned MAX_SRC = 16;

   // Index of the highest set bit; zero when the vector is empty.
   function automatic int unsigned top_index(input logic [MAX_SRC-1:0] v);
      int unsigned idx;
      idx = 0;
      for (int unsigned i = 0; i < MAX_SRC; i++) begin
         if (v[i]) idx = i;
      end
      return idx;
   endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_in,
   input  logic             clr_valid,
   input  logic [ID_W-1:0]  clr_id,
   output logic [N_SRC-1:0] pend,
   output logic [N_SRC-1:0] arrive
);

   for (genvar g = 0; g < N_SRC; g++) begin : g_cell
      logic hit_clr;
      logic pend_q;

      assign hit_clr = clr_valid && (clr_id == ID_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) pend_q <= 1'b0;
         else        pend_q <= (pend_q && !hit_clr) || irq_in[g];
      end

      assign pend[g]   = pend_q;
      // New queue entry: request seen while the class is not (or no longer) pending
      assign arrive[g] = irq_in[g] && (!pend_q || hit_clr);
   end

endmodule

// File: rtl/irq_order_queue.sv
module irq_order_queue #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned CNT_W = $clog2(N_SRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] arrive,
   input  logic             rm_valid,
   input  logic [ID_W-1:0]  rm_id,
   output logic [ID_W-1:0]  head_id,
   output logic [CNT_W-1:0] q_cnt,
   output logic             q_empty
);

   logic [ID_W-1:0]  slot_q [N_SRC];
   logic [ID_W-1:0]  slot_d [N_SRC];
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      int unsigned n;
      n = 0;
      for (int unsigned k = 0; k < N_SRC; k++) slot_d[k] = slot_q[k];
      // Drop the acknowledged class wherever it sits, keep the rest in order
      for (int unsigned k = 0; k < N_SRC; k++) begin
         if ((k < 32'(cnt_q)) && !(rm_valid && (slot_q[k] == rm_id)) && (n < N_SRC)) begin
            slot_d[n] = slot_q[k];
            n = n + 1;
         end
      end
      // Append new arrivals; same-cycle arrivals go higher code first
      for (int k = int'(N_SRC) - 1; k >= 0; k--) begin
         if (arrive[k] && (n < N_SRC)) begin
            slot_d[n] = ID_W'(k);
            n = n + 1;
         end
      end
      cnt_d = CNT_W'(n);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int unsigned k = 0; k < N_SRC; k++) slot_q[k] <= '0;
      end else begin
         cnt_q <= cnt_d;
         for (int unsigned k = 0; k < N_SRC; k++) slot_q[k] <= slot_d[k];
      end
   end

   assign head_id = slot_q[0];
   assign q_cnt   = cnt_q;
   assign q_empty = (cnt_q == '0);

endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_valid,
   input  logic [ID_W-1:0]  set_id,
   input  logic             end_valid,
   output logic [N_SRC-1:0] isr,
   output logic             busy,
   output logic [ID_W-1:0]  active_id
);

   logic [N_SRC-1:0] isr_q;
   logic [N_SRC-1:0] top_oh;
   logic [N_SRC-1:0] set_oh;

   assign active_id = ID_W'(irq_arb_pkg::top_index(irq_arb_pkg::MAX_SRC'(isr_q)));
   assign top_oh    = (isr_q != '0) ? (N_SRC'(1) << active_id) : '0;
   assign set_oh    = set_valid ? (N_SRC'(1) << set_id) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~(end_valid ? top_oh : '0)) | set_oh;
   end

   assign isr  = isr_q;
   assign busy = (isr_q != '0);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_nested,
   input  logic [N_SRC-1:0] irq_in,
   output logic             cpu_req,
   output logic [ID_W-1:0]  cpu_class,
   input  logic             cpu_ack,
   input  logic             cpu_eoi
);

   localparam int unsigned CNT_W = $clog2(N_SRC + 1);

   initial begin
      assert (N_SRC >= 2 && N_SRC <= irq_arb_pkg::MAX_SRC)
         else $fatal(1, "irq_arbiter: N_SRC out of range");
   end

   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] arrive;
   logic [N_SRC-1:0] isr;
   logic [ID_W-1:0]  head_id;
   logic [CNT_W-1:0] q_cnt;
   logic             q_empty;
   logic             busy;
   logic [ID_W-1:0]  active_id;
   logic [ID_W-1:0]  hp_id;
   logic             take;

   assign take = cpu_req && cpu_ack;

   irq_pend_bank #(.N_SRC(N_SRC)) i_pend (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .clr_valid(take), .clr_id(cpu_class),
      .pend(pend), .arrive(arrive)
   );

   irq_order_queue #(.N_SRC(N_SRC)) i_queue (
      .clk(clk), .rst_n(rst_n), .arrive(arrive),
      .rm_valid(take), .rm_id(cpu_class),
      .head_id(head_id), .q_cnt(q_cnt), .q_empty(q_empty)
   );

   irq_nest_tracker #(.N_SRC(N_SRC)) i_nest (
      .clk(clk), .rst_n(rst_n),
      .set_valid(take), .set_id(cpu_class), .end_valid(cpu_eoi),
      .isr(isr), .busy(busy), .active_id(active_id)
   );

   assign hp_id = ID_W'(irq_arb_pkg::top_index(irq_arb_pkg::MAX_SRC'(pend)));

   always_comb begin
      if (mode_nested) begin
         cpu_req   = (pend != '0) && (!busy || (hp_id > active_id));
         cpu_class = hp_id;
      end else begin
         cpu_req   = !busy && !q_empty;
         cpu_class = head_id;
      end
   end

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
   parameter int unsigned N_SRC = 4,
   localparam int unsigned ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned CNT_W = $clog2(N_SRC + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_nested,
   input logic [N_SRC-1:0] irq_in,
   input logic             cpu_req,
   input logic [ID_W-1:0]  cpu_class,
   input logic             cpu_ack,
   input logic             cpu_eoi,
   input logic [N_SRC-1:0] pend,
   input logic [N_SRC-1:0] isr,
   input logic [CNT_W-1:0] q_cnt,
   input logic [ID_W-1:0]  active_id
);

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (isr == '0 && pend == '0 && !cpu_req));

   // R2
   latch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in != '0) |=> (pend != '0));

   // R3
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_ack && !irq_in[cpu_class]) |=> !pend[$past(cpu_class)]);

   // R4
   seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_nested && isr != '0) |-> !cpu_req);

   // R6
   queue_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(q_cnt) == $countones(pend));

   // R7
   nest_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_nested && isr != '0 && cpu_req) |-> (cpu_class > active_id));

   // R9
   eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_eoi && !(cpu_req && cpu_ack) && isr != '0)
         |=> ($countones(isr) + 1 == $past($countones(isr))));

endmodule

bind irq_arbiter irq_arbiter_chk #(.N_SRC(N_SRC)) i_chk (
   .clk(clk), .rst_n(rst_n), .mode_nested(mode_nested), .irq_in(irq_in),
   .cpu_req(cpu_req), .cpu_class(cpu_class), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi),
   .pend(pend), .isr(isr), .q_cnt(q_cnt), .active_id(active_id)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;

   localparam int unsigned N = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_nested = 1'b0;
   logic [3:0] irq_in = '0;
   logic       cpu_req;
   logic [1:0] cpu_class;
   logic       cpu_ack = 1'b0;
   logic       cpu_eoi = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_arbiter #(.N_SRC(N)) i_irq_arbiter (
      .clk(clk), .rst_n(rst_n), .mode_nested(mode_nested), .irq_in(irq_in),
      .cpu_req(cpu_req), .cpu_class(cpu_class), .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Offered class as one number: -1 when nothing is offered
   function automatic int offered();
      return cpu_req ? int'(cpu_class) : -1;
   endfunction

   task automatic pulse(input logic [3:0] m);
      @(negedge clk) irq_in = m;
      @(negedge clk) irq_in = '0;
   endtask

   task automatic do_ack();
      @(negedge clk) cpu_ack = 1'b1;
      @(negedge clk) cpu_ack = 1'b0;
   endtask

   task automatic do_eoi();
      @(negedge clk) cpu_eoi = 1'b1;
      @(negedge clk) cpu_eoi = 1'b0;
   endtask

   task automatic restart(input logic nested);
      @(negedge clk) rst_n = 1'b0;
      mode_nested = nested;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state, even with requests driven during reset
      irq_in = 4'hF;
      repeat (3) @(negedge clk);
      chk("R1 req in reset", offered(), -1);
      irq_in = '0;
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req after reset", offered(), -1);

      // R5 / R4 / R2: every arrival order in sequential mode
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++) begin
                  int perm[4];
                  if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                  perm = '{a, b, c, d};
                  restart(1'b0);
                  for (int k = 0; k < 4; k++) pulse(4'(1 << perm[k]));
                  for (int k = 0; k < 4; k++) begin
                     chk("R5 arrival order", offered(), perm[k]);
                     do_ack();
                     chk("R4 hold while busy", offered(), -1);
                     do_eoi();
                  end
                  chk("R3 drained", offered(), -1);
               end

      // R5: same-cycle arrivals, higher code first
      restart(1'b0);
      pulse(4'b1011);
      for (int k = 0; k < 3; k++) begin
         int exp_tbl[3];
         exp_tbl = '{3, 1, 0};
         chk("R5 same-cycle tie", offered(), exp_tbl[k]);
         do_ack();
         do_eoi();
      end
      chk("R5 tie drained", offered(), -1);

      // R6: repeat pulse for a pending class is served once
      restart(1'b0);
      pulse(4'b0100);
      pulse(4'b0100);
      pulse(4'b0010);
      chk("R6 first", offered(), 2);
      do_ack();
      do_eoi();
      chk("R6 next is other class", offered(), 1);
      do_ack();
      do_eoi();
      chk("R6 no duplicate", offered(), -1);

      // R10 / R4: re-request of the class in service
      restart(1'b0);
      pulse(4'b1000);
      do_ack();
      pulse(4'b1000);
      chk("R4 relatch held", offered(), -1);
      do_eoi();
      chk("R10 relatched", offered(), 3);
      do_ack();
      do_eoi();
      chk("R10 drained", offered(), -1);

      // Nested mode: every ordered pair (active, newcomer)
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++) begin
            restart(1'b1);
            pulse(4'(1 << a));
            chk("R2 offer", offered(), a);
            do_ack();
            pulse(4'(1 << b));
            if (b > a) begin
               chk("R7 preempt", offered(), b);
               if (a > 0) begin
                  pulse(4'b0001);
                  chk("R7 highest offered", offered(), b);
               end
               do_ack();
               chk("R3 ack clears", offered(), -1);
               do_eoi();
               chk("R9 back to preempted", offered(), -1);
               do_eoi();
               if (a > 0) begin
                  chk("R9 lower after unwind", offered(), 0);
                  do_ack();
                  do_eoi();
               end
            end else begin
               chk("R8 equal or lower waits", offered(), -1);
               do_eoi();
               chk(b == a ? "R10 nested relatch" : "R8 served after end", offered(), b);
               do_ack();
               do_eoi();
            end
            chk("R9 idle at end", offered(), -1);
         end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule